// File: doc/BRIEF.md
# Compare-Match Interval Timer Channel

This block is one channel of a periodic interval timer. A free-running divider turns the system clock into slow counting ticks, at a ratio that the control register selects. While the channel's run bit is set, an up-counter advances on each tick. When the counter equals the compare register at a tick, it returns to zero and a sticky match flag is set. The period is therefore compare+1 ticks. The interrupt output is the match flag gated by an enable bit. Software clears the flag by writing zero to it.

The counter is 16 or 32 bits wide, chosen by parameter, and the control layout follows that choice. A write to the counter does not apply at once. It is held pending and loaded two slow ticks later. Until then, readback still shows the running count. The four registers sit behind a simple single-cycle bus. Writes take effect at a clock edge, and reads are combinational from the word address.

Top module: `cmtimer_chan`

## Requirements
- R1: After reset the run register reads 0, the control register reads 0, the counter reads 0, the compare register reads all ones of the counter width, and the interrupt output is low.
- R2: Word address 0 is the run register, a full 32-bit read/write word. Only bit RUN_BIT (default 0) gates counting, and its other bits read back as written. While that bit is 0, the counter holds its value.
- R3: While running, the counter steps by one on each slow tick. On a tick where it equals the compare value (address 3), it returns to 0 and the match flag is set. Successive flag events are therefore (compare+1) ticks apart.
- R4: The low control bits (address 1) pick the tick ratio. For a code c in bits [1:0], the divide is 8·4^c: 0 gives /8 and 3 gives /512. In the 32-bit variant, code 7 in bits [2:0] gives /1, and code 4 gives /8.
- R5: The compare register applies from the next tick on. If the counter is already above the new compare value, it runs up to all ones and wraps to 0 before any match occurs.
- R6: The match flag is set only by a match. Writing 0 to the flag bit clears it, and writing 1 leaves it unchanged. The other control bits read back as written.
- R7: The interrupt output is high exactly when the match flag is set and the interrupt-enable bit is set. The enable bit is bit 6 in the 16-bit variant and bit 5 in the 32-bit variant.
- R8: A counter write (address 2) is not visible on readback right away. It loads on the second slow tick after the write, and the pending value is applied whether or not the channel runs.
- R9: If a match and a flag-clearing control write happen in the same cycle, the flag ends up set.
- R10: In the 32-bit variant the flag is control bit 15 and bit 14 reads 0. A write with bits 15 and 14 at zero clears the flag. Control value 0x01A4 reads back as written and gives a /8 tick with the interrupt enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Word address: 0 run, 1 control, 2 counter, 3 compare |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, zero-extended |
| irq | output | 1 | Level interrupt: match flag AND enable |

## Verification
The hardest case to reach is R9: a flag-clearing write that lands in the same clock edge as a match. The bench runs the channel at a known period of 40 cycles. It detects the cycle in which the flag rises and clears the flag at once. It then counts clocks so that a second clearing write is sampled on the edge where the next match registers. The flag must read back as set. The full-scale wrap in R5 would need too many ticks from reset. The bench reaches it by committing a counter value just below all ones, then lowering the compare value beneath it.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

  typedef enum logic [1:0] {
    RG_RUN = 2'd0,
    RG_CTL = 2'd1,
    RG_CNT = 2'd2,
    RG_CMP = 2'd3
  } cmt_reg_e;

  // Tick ratio code to shift amount: divide = 2**shift.
  function automatic logic [3:0] cks_to_shift(input logic [2:0] code, input logic wide);
    logic [3:0] sh;
    if (wide && (code == 3'd7)) sh = 4'd0;
    else                        sh = 4'd3 + {1'b0, code[1:0], 1'b0};
    return sh;
  endfunction

endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
  parameter int PRE_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] shift,
  output logic       tick
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;
  logic [PRE_W-1:0] mask;

  always_comb begin
    pre_d = pre_q + 1'b1;
    mask  = (PRE_W'(1) << shift) - PRE_W'(1);
  end

  assign tick = &(pre_q | ~mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

endmodule

// File: rtl/cmt_count_core.sv
module cmt_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic [CNT_W-1:0] cmp,
  input  logic             wr_cnt,
  input  logic [CNT_W-1:0] wr_val,
  output logic [CNT_W-1:0] cnt,
  output logic             match_ev
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] pval_q, pval_d;
  logic             pend_q, pend_d;
  logic             pstep_q, pstep_d;
  logic             commit;
  logic             cnt_en, pend_en;

  always_comb begin
    commit   = pend_q && tick && pstep_q && !wr_cnt;
    match_ev = tick && run && !commit && (cnt_q == cmp);
    cnt_en   = commit || (tick && run);
    if (commit)        cnt_d = pval_q;
    else if (match_ev) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;

    pend_en = wr_cnt || (pend_q && tick);
    pval_d  = pval_q;
    pend_d  = pend_q;
    pstep_d = pstep_q;
    if (wr_cnt) begin
      pval_d  = wr_val;
      pend_d  = 1'b1;
      pstep_d = 1'b0;
    end else if (pstep_q) begin
      pend_d  = 1'b0;
      pstep_d = 1'b0;
    end else begin
      pstep_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pval_q  <= '0;
      pend_q  <= 1'b0;
      pstep_q <= 1'b0;
    end else if (pend_en) begin
      pval_q  <= pval_d;
      pend_q  <= pend_d;
      pstep_q <= pstep_d;
    end
  end

  assign cnt = cnt_q;

  // R3
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_ev |=> (cnt_q == '0));

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(pend_q && tick)) |=> $stable(cnt_q));

  // R8
  commit_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt && !(tick && run)) |=> $stable(cnt_q));

endmodule

// File: rtl/cmt_regs.sv
module cmt_regs #(
  parameter int CNT_W   = 16,
  parameter int RUN_BIT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  input  logic             match_ev,
  output logic [31:0]      run_reg,
  output logic [15:0]      ctl,
  output logic [CNT_W-1:0] cmp,
  output logic             run,
  output logic             ie,
  output logic [3:0]       shift,
  output logic             wr_cnt
);
  import cmt_pkg::*;

  localparam logic       WIDE      = (CNT_W == 32);
  localparam int         FLAG_BIT  = WIDE ? 15 : 7;
  localparam int         IE_BIT    = WIDE ? 5 : 6;
  localparam logic [15:0] KEEP_MASK = WIDE ? 16'h3FFF : 16'h007F;

  logic [31:0]      run_q;
  logic [15:0]      norm_q, norm_d;
  logic             flag_q, flag_d;
  logic [CNT_W-1:0] cmp_q;
  logic             wr_run, wr_ctl, wr_cmp;

  always_comb begin
    wr_run = bus_we && (bus_addr == RG_RUN);
    wr_ctl = bus_we && (bus_addr == RG_CTL);
    wr_cnt = bus_we && (bus_addr == RG_CNT);
    wr_cmp = bus_we && (bus_addr == RG_CMP);
    norm_d = bus_wdata[15:0] & KEEP_MASK;
    flag_d = match_ev || (flag_q && !(wr_ctl && !bus_wdata[FLAG_BIT]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (wr_run) run_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      norm_q <= '0;
    else if (wr_ctl) norm_q <= norm_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '1;
    else if (wr_cmp) cmp_q <= bus_wdata[CNT_W-1:0];
  end

  always_comb begin
    ctl           = norm_q;
    ctl[FLAG_BIT] = flag_q;
  end

  assign run_reg = run_q;
  assign run     = run_q[RUN_BIT];
  assign ie      = norm_q[IE_BIT];
  assign cmp     = cmp_q;
  assign shift   = cks_to_shift(norm_q[2:0], WIDE);

  // R9
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_ev |=> flag_q);

  // R6
  flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(match_ev));

endmodule

// File: rtl/cmtimer_chan.sv
module cmtimer_chan #(
  parameter int CNT_W   = 16,
  parameter int RUN_BIT = 0,
  parameter int PRE_W   = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  import cmt_pkg::*;

  logic [31:0]      run_reg;
  logic [15:0]      ctl;
  logic [CNT_W-1:0] cmp, cnt;
  logic             run, ie, wr_cnt, tick, match_ev;
  logic [3:0]       shift;

  cmt_regs #(.CNT_W(CNT_W), .RUN_BIT(RUN_BIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .match_ev(match_ev), .run_reg(run_reg),
    .ctl(ctl), .cmp(cmp), .run(run), .ie(ie), .shift(shift), .wr_cnt(wr_cnt)
  );

  cmt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .shift(shift), .tick(tick)
  );

  cmt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .cmp(cmp),
    .wr_cnt(wr_cnt), .wr_val(bus_wdata[CNT_W-1:0]), .cnt(cnt),
    .match_ev(match_ev)
  );

  always_comb begin
    unique case (cmt_reg_e'(bus_addr))
      RG_RUN:  bus_rdata = run_reg;
      RG_CTL:  bus_rdata = 32'(ctl);
      RG_CNT:  bus_rdata = 32'(cnt);
      default: bus_rdata = 32'(cmp);
    endcase
  end

  assign irq = ie && ((CNT_W == 32) ? ctl[15] : ctl[7]);

endmodule

// File: tb/cmtimer_chan_test.sv
module cmtimer_chan_test;

  typedef struct {
    logic [31:0] exp;
    logic [31:0] msk;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic        sel = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rd16, rd32, rdata;
  logic        irq16, irq32, irq_m;
  int          checks = 0;
  int          errs = 0;
  longint      cyc = 0;
  item_t       sbq[$];
  event        rd_ev;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cmtimer_chan #(.CNT_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .bus_we(we && !sel), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rd16), .irq(irq16)
  );

  cmtimer_chan #(.CNT_W(32)) uut32 (
    .clk(clk), .rst_n(rst_n), .bus_we(we && sel), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rd32), .irq(irq32)
  );

  assign rdata = sel ? rd32 : rd16;
  assign irq_m = sel ? irq32 : irq16;

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp, input logic [31:0] msk);
    checks++;
    if ((act & msk) !== (exp & msk)) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act & msk, exp & msk);
    end
  endtask

  // Monitor: pops expected read items and compares against the bus.
  initial begin
    forever begin
      item_t it;
      @(rd_ev);
      it = sbq.pop_front();
      check(it.tag, rdata, it.exp, it.msk);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] e,
                    input logic [31:0] m, input string tag);
    @(negedge clk);
    addr = a;
    sbq.push_back('{exp: e, msk: m, tag: tag});
    #1 -> rd_ev;
    #1;
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic wait_irq();
    do @(negedge clk); while (!irq_m);
  endtask

  task automatic period(input logic [31:0] clr, input longint want, input string tag);
    longint t0;
    wr(2'd1, clr);
    wait_irq();
    t0 = cyc;
    wr(2'd1, clr);
    wait_irq();
    check(tag, 32'(cyc - t0), 32'(want), 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, 16-bit
    rd(2'd0, 32'h0, 32'hFFFF_FFFF, "R1 run");
    rd(2'd1, 32'h0, 32'hFFFF_FFFF, "R1 ctl");
    rd(2'd2, 32'h0, 32'hFFFF_FFFF, "R1 cnt");
    rd(2'd3, 32'h0000_FFFF, 32'hFFFF_FFFF, "R1 cmp");
    check("R1 irq", 32'(irq_m), 32'h0, 32'h1);

    // R2 run bit clear: counter holds, other bits kept
    wr(2'd0, 32'h0000_00A0);
    repeat (40) @(negedge clk);
    rd(2'd2, 32'h0, 32'hFFFF_FFFF, "R2 hold");
    rd(2'd0, 32'h0000_00A0, 32'hFFFF_FFFF, "R2 keep");

    // R3 period (4+1) ticks at /8
    wr(2'd3, 32'd4);
    wr(2'd1, 32'h40);
    wr(2'd0, 32'h0000_00A1);
    rd(2'd0, 32'h0000_00A1, 32'hFFFF_FFFF, "R2 start");
    period(32'h40, 40, "R3 period");

    // R4 divide-by-512, compare 1
    wr(2'd3, 32'd1);
    period(32'h43, 1024, "R4 div512");

    // R6 / R7 flag and interrupt
    wr(2'd3, 32'd4);
    wr(2'd1, 32'h40);
    wait_irq();
    wr(2'd1, 32'hC0);
    rd(2'd1, 32'hC0, 32'hFF, "R6 write1 keeps");
    wr(2'd1, 32'h80);
    check("R7 ie off", 32'(irq_m), 32'h0, 32'h1);
    rd(2'd1, 32'h80, 32'hFF, "R6 flag kept");
    wr(2'd1, 32'hC0);
    check("R7 ie on", 32'(irq_m), 32'h1, 32'h1);
    wr(2'd1, 32'h40);
    rd(2'd1, 32'h40, 32'hFF, "R6 clear");
    check("R7 cleared", 32'(irq_m), 32'h0, 32'h1);

    // R9 clear coinciding with match (period 40)
    wait_irq();
    wr(2'd1, 32'h40);
    repeat (36) @(negedge clk);
    wr(2'd1, 32'h40);
    rd(2'd1, 32'h80, 32'h80, "R9 coincide");

    // R8 delayed counter write (stopped, /8)
    wr(2'd0, 32'h0000_00A0);
    wr(2'd1, 32'h40);
    peek(2'd2, v);
    wr(2'd2, 32'h0123);
    rd(2'd2, v, 32'hFFFF_FFFF, "R8 not yet");
    repeat (20) @(negedge clk);
    rd(2'd2, 32'h0123, 32'hFFFF_FFFF, "R8 committed");

    // R5 compare lowered beneath counter: wrap at full scale
    wr(2'd2, 32'hFFF0);
    repeat (20) @(negedge clk);
    wr(2'd3, 32'd5);
    wr(2'd0, 32'h0000_00A1);
    repeat (80) @(negedge clk);
    rd(2'd1, 32'h0, 32'h80, "R5 no early match");
    repeat (120) @(negedge clk);
    rd(2'd1, 32'h80, 32'h80, "R5 match after wrap");
    peek(2'd2, v);
    check("R5 small count", 32'(v <= 32'd5), 32'h1, 32'h1);

    // R10 32-bit variant
    sel = 1'b1;
    rd(2'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1 cmp32");
    rd(2'd1, 32'h0, 32'hFFFF_FFFF, "R1 ctl32");
    wr(2'd1, 32'h0000_01A4);
    rd(2'd1, 32'h0000_01A4, 32'hFFFF, "R10 ctl");
    wr(2'd3, 32'd3);
    wr(2'd0, 32'h1);
    period(32'h0000_01A4, 32, "R10 period");
    rd(2'd1, 32'h8000, 32'hC000, "R10 flag");
    wr(2'd1, 32'h0000_01A4);
    rd(2'd1, 32'h0, 32'hC000, "R10 clear");
    check("R10 irq low", 32'(irq_m), 32'h0, 32'h1);

    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

endmodule